// File: doc/BRIEF.md
# Strap-Dependent Port Mode Controller

This block sets the function of an eight-pin general-purpose port. A 16-bit control word holds one 2-bit mode field per pin. Each field chooses between two uses of the pin. In the first, an on-chip peripheral drives the pad's output enable and output value. In the second, the pin is a port input, with the input pull-up either on or off. In port-input modes the pad level passes through a two-stage synchroniser and appears on a port data output. All pad-facing outputs are registered.

There are two reset inputs. Power-on reset reloads the control word with one of two images. Pin 6 doubles as a strap input while power-on reset is held, and its level in the last reset cycle chooses the image. After reset, pin 6 is an ordinary port input. Manual reset clears the output and synchroniser registers but leaves the control word alone, so the software-chosen pin functions survive it.

Top module: `pin_mode_ctl`

## Requirements
- R1: Pin n is controlled by the field at bits 2n+1:2n of the control word (pin 0 in bits 1:0, pin 7 in bits 15:14). The mode of one pin does not affect any other pin.
- R2: Mode 2'b00 is the alternate function. `pad_oe` and `pad_out` for that pin follow `alt_oe_i` and `alt_out_i`, while `pull_en` and `port_data` are 0.
- R3: Mode 2'b10 is port input with pull-up. `pull_en` is 1 and `pad_oe` and `pad_out` are 0. `port_data` shows the pad level three clock edges after it changes (two synchroniser stages plus the output register).
- R4: Mode 2'b11 is port input without pull-up. `pull_en`, `pad_oe` and `pad_out` are 0, and `port_data` follows the pad as in R3.
- R5: Mode 2'b01 is reserved. The pin behaves as in R4, and a read returns the stored 01.
- R6: While power-on reset is high, all pad outputs, pull-ups and port data are 0. If pin 6 is high in the last cycle of power-on reset, the control word reads 16'hAAAA afterwards.
- R7: If pin 6 is low in the last cycle of power-on reset, the control word reads 16'hA200 afterwards. Pin 6 levels in earlier reset cycles do not matter.
- R8: Manual reset forces all outputs to 0 while it is held. It keeps the control word, and the previous pin functions return once it is released.
- R9: All sixteen control bits are writable and read back. A write takes effect at the clock edge where `bus_wr` is high. A read pulse loads `bus_rdata` at its clock edge.
- R10: A write presented during manual reset is discarded.
- R11: After power-on reset is released, pin 6 acts as an ordinary port input whose level reaches `port_data[6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| bus_wr | input | 1 | Control word write strobe |
| bus_rd | input | 1 | Control word read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| alt_oe_i | input | 8 | Per-pin output enable from peripherals |
| alt_out_i | input | 8 | Per-pin output value from peripherals |
| pad_in | input | 8 | Pad levels (pin 6 is also the strap) |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pull_en | output | 8 | Pull-up enable |
| port_data | output | 8 | Synchronised port input data |

## Verification
The bench changes the strap level in the final power-on reset cycle. A design that latched the strap early, or latched it from the synchronised path, would load 16'hAAAA where 16'hA200 belongs. It asserts manual reset together with a write. A design that honoured the write, or reset the control word, would read back something other than the earlier value. Mixed mode words such as 16'hE4E4 and 16'h1B1B catch field swaps and a reserved code that drives the pad or turns on the pull-up. A latency probe catches a synchroniser with the wrong number of stages.

// File: rtl/pin_mode_pkg.sv
package pin_mode_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ALT    = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_PULLUP = 2'b10,
    MODE_FLOAT  = 2'b11
  } pin_mode_e;

endpackage

// File: rtl/pin_mode_sync.sv
module pin_mode_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pin_mode_ctl_reg.sv
module pin_mode_ctl_reg
  import pin_mode_pkg::*;
#(
  parameter int             NPINS     = 8,
  parameter logic [NPINS-1:0] KEEP_MASK = 8'hD0,
  localparam int            W         = NPINS * MODE_W
) (
  input  logic         clk,
  input  logic         por_rst,
  input  logic         man_rst,
  input  logic         strap_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] ctl_o
);

  logic [W-1:0] img_strap_hi;
  logic [W-1:0] img_strap_lo;
  logic [W-1:0] ctl_q;
  logic [W-1:0] rdata_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_img
    assign img_strap_hi[MODE_W*g +: MODE_W] = MODE_PULLUP;
    assign img_strap_lo[MODE_W*g +: MODE_W] = KEEP_MASK[g] ? MODE_PULLUP : MODE_ALT;
  end

  // Image re-selected every cycle of power-on reset: last cycle wins.
  always_ff @(posedge clk) begin
    if (por_rst) begin
      ctl_q   <= strap_i ? img_strap_hi : img_strap_lo;
      rdata_q <= '0;
    end else begin
      if (wr_i && !man_rst) ctl_q <= wdata_i;
      if (rd_i)             rdata_q <= ctl_q;
    end
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = rdata_q;

  AST_MAN_RST_HOLDS: assert property (@(posedge clk) disable iff (por_rst)
    man_rst |=> $stable(ctl_q)); // R8

  AST_POR_IMAGE: assert property (@(posedge clk) disable iff (por_rst)
    $past(por_rst) |-> (ctl_q == ($past(strap_i) ? img_strap_hi : img_strap_lo))); // R7

  AST_RD_ECHO: assert property (@(posedge clk) disable iff (por_rst)
    rd_i |=> (rdata_q == $past(ctl_q))); // R9

endmodule

// File: rtl/pin_mode_slice.sv
module pin_mode_slice
  import pin_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              alt_oe_i,
  input  logic              alt_out_i,
  input  logic              pad_sync_i,
  output logic              oe_o,
  output logic              out_o,
  output logic              pu_o,
  output logic              data_o
);

  logic is_alt;
  logic oe_q, out_q, pu_q, data_q;

  assign is_alt = (mode_i == MODE_ALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      out_q  <= 1'b0;
      pu_q   <= 1'b0;
      data_q <= 1'b0;
    end else begin
      oe_q   <= is_alt & alt_oe_i;
      out_q  <= is_alt & alt_out_i;
      pu_q   <= (mode_i == MODE_PULLUP);
      data_q <= !is_alt & pad_sync_i;
    end
  end

  assign oe_o   = oe_q;
  assign out_o  = out_q;
  assign pu_o   = pu_q;
  assign data_o = data_q;

  AST_OE_ALT_ONLY: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> ($past(mode_i) == MODE_ALT)); // R2

  AST_PULL_MATCH: assert property (@(posedge clk) disable iff (rst)
    pu_q |-> ($past(mode_i) == MODE_PULLUP)); // R3

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RSVD) |=> (!pu_q && !oe_q && !out_q)); // R5

endmodule

// File: rtl/pin_mode_ctl.sv
module pin_mode_ctl
  import pin_mode_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_PIN   = 6,
  parameter logic [NPINS-1:0] KEEP_MASK = 8'hD0,
  localparam int W          = NPINS * MODE_W
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             man_rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic [NPINS-1:0] alt_oe_i,
  input  logic [NPINS-1:0] alt_out_i,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pull_en,
  output logic [NPINS-1:0] port_data
);

  logic             any_rst;
  logic [W-1:0]     ctl;
  logic [NPINS-1:0] pad_sync;

  assign any_rst = por_rst | man_rst;

  pin_mode_ctl_reg #(
    .NPINS     (NPINS),
    .KEEP_MASK (KEEP_MASK)
  ) u_ctl_reg (
    .clk     (clk),
    .por_rst (por_rst),
    .man_rst (man_rst),
    .strap_i (pad_in[STRAP_PIN]),
    .wr_i    (bus_wr),
    .rd_i    (bus_rd),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata),
    .ctl_o   (ctl)
  );

  pin_mode_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (any_rst),
    .d_i (pad_in),
    .q_o (pad_sync)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_mode_slice u_slice (
      .clk        (clk),
      .rst        (any_rst),
      .mode_i     (ctl[MODE_W*p +: MODE_W]),
      .alt_oe_i   (alt_oe_i[p]),
      .alt_out_i  (alt_out_i[p]),
      .pad_sync_i (pad_sync[p]),
      .oe_o       (pad_oe[p]),
      .out_o      (pad_out[p]),
      .pu_o       (pull_en[p]),
      .data_o     (port_data[p])
    );
  end

  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (1'b0)
    $past(any_rst) && $past(any_rst, 2) |-> (pad_oe == '0 && pull_en == '0 && port_data == '0)); // R6

endmodule

// File: tb/pin_mode_ctl_bench.sv
module pin_mode_ctl_bench;

  logic        clk = 1'b0;
  logic        por_rst = 1'b1;
  logic        man_rst = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  alt_oe_i = '0;
  logic [7:0]  alt_out_i = '0;
  logic [7:0]  pad_in = 8'h40;
  logic [7:0]  pad_oe, pad_out, pull_en, port_data;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  pin_mode_ctl u_pin_mode_ctl (
    .clk       (clk),
    .por_rst   (por_rst),
    .man_rst   (man_rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .alt_oe_i  (alt_oe_i),
    .alt_out_i (alt_out_i),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pull_en   (pull_en),
    .port_data (port_data)
  );

  // {mode word, alt_oe, alt_out, pad}
  localparam logic [39:0] VEC [6] = '{
    {16'h0000, 8'hA5, 8'h3C, 8'hFF},
    {16'hAAAA, 8'hFF, 8'hFF, 8'h5A},
    {16'hFFFF, 8'hFF, 8'h00, 8'hC3},
    {16'h5555, 8'hFF, 8'hFF, 8'h96},
    {16'hE4E4, 8'hFF, 8'h0F, 8'hFF},
    {16'h1B1B, 8'hF0, 8'hFF, 8'h0F}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R1";
    endcase
  endfunction

  // Expected {oe, out, pull, data} from the mode rules.
  function automatic logic [31:0] model(logic [15:0] w, logic [7:0] aoe,
                                        logic [7:0] aout, logic [7:0] pad);
    logic [7:0] oe, o, pu, d;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] m;
      m     = w[2*i +: 2];
      oe[i] = (m == 2'b00) & aoe[i];
      o[i]  = (m == 2'b00) & aout[i];
      pu[i] = (m == 2'b10);
      d[i]  = (m != 2'b00) & pad[i];
    end
    return {oe, o, pu, d};
  endfunction

  task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] v);
    bus_wr = 1'b1; bus_wdata = v;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(string req, logic [15:0] exp);
    bus_rd = 1'b1;
    tick(1);
    bus_rd = 1'b0;
    check(req, "readback", bus_rdata, exp);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    @(negedge clk);
    tick(3);
    // R6: outputs quiet during power-on reset
    check("R6", "pad_oe in reset", {8'h0, pad_oe}, 16'h0);
    check("R6", "pull_en in reset", {8'h0, pull_en}, 16'h0);
    por_rst = 1'b0;
    tick(1);
    rd_check("R6", 16'hAAAA);

    // R7: strap low only in the final reset cycle
    por_rst = 1'b1; pad_in = 8'h40;
    tick(3);
    pad_in = 8'h00;
    tick(1);
    por_rst = 1'b0;
    tick(1);
    rd_check("R7", 16'hA200);

    // R11: pin 6 is a port input after reset
    pad_in = 8'h40;
    tick(4);
    check("R11", "port_data pin6 high", {8'h0, port_data}, 16'h0040);
    pad_in = 8'h00;
    tick(4);
    check("R11", "port_data pin6 low", {8'h0, port_data}, 16'h0000);

    // Table walk: R1..R5
    for (int i = 0; i < 6; i++) begin
      logic [39:0] v;
      v = VEC[i];
      wr(v[39:24]);
      alt_oe_i = v[23:16]; alt_out_i = v[15:8]; pad_in = v[7:0];
      tick(4);
      e = model(v[39:24], v[23:16], v[15:8], v[7:0]);
      check(vec_tag(i), "pad_oe",    {8'h0, pad_oe},    {8'h0, e[31:24]});
      check(vec_tag(i), "pad_out",   {8'h0, pad_out},   {8'h0, e[23:16]});
      check(vec_tag(i), "pull_en",   {8'h0, pull_en},   {8'h0, e[15:8]});
      check(vec_tag(i), "port_data", {8'h0, port_data}, {8'h0, e[7:0]});
    end
    // R5: reserved code reads back as written
    rd_check("R5", 16'h1B1B);

    // R1: single field for pin 5
    wr(16'h0C00); alt_oe_i = 8'hFF; alt_out_i = 8'hFF; pad_in = 8'hFF;
    tick(3);
    check("R1", "pad_oe pin5 only off", {8'h0, pad_oe}, 16'h00DF);
    check("R1", "port_data pin5 only", {8'h0, port_data}, 16'h0020);

    // R3: synchroniser latency of three edges
    wr(16'hAAAA); pad_in = 8'h00;
    tick(4);
    pad_in = 8'hFF;
    tick(2);
    check("R3", "port_data after 2 edges", {8'h0, port_data}, 16'h0000);
    tick(1);
    check("R3", "port_data after 3 edges", {8'h0, port_data}, 16'h00FF);

    // R9: full-width read/write
    wr(16'h5A3C);
    rd_check("R9", 16'h5A3C);
    wr(16'hC3A5);
    rd_check("R9", 16'hC3A5);

    // R8 / R10: manual reset keeps the word and drops writes
    wr(16'h0000); alt_oe_i = 8'hFF;
    tick(2);
    check("R8", "pad_oe before manual reset", {8'h0, pad_oe}, 16'h00FF);
    man_rst = 1'b1;
    wr(16'h1234);
    check("R8", "pad_oe in manual reset", {8'h0, pad_oe}, 16'h0000);
    man_rst = 1'b0;
    rd_check("R10", 16'h0000);
    tick(1);
    check("R8", "pad_oe after manual reset", {8'h0, pad_oe}, 16'h00FF);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule